// File: doc/BRIEF.md
# Multi-Tower Scan Path Configurator

This block sits in the base logic die of a stack that carries two neighbouring dies side by side: a memory die with four independent channels (the "north" tower) and a DRAM die with its own wrapper (the "east" tower). It stitches one serial test path between the TAP data input and output. The path is built from the base die's package-pin boundary cells, its wrapper cells facing each neighbour, the DRAM die's wrapper chain, and the boundary cells of each memory channel. The segment set is chosen by a wrapper instruction. That instruction is shifted in through the TAP instruction-register states and takes effect only on Update-IR.

The memory die has no test controller of its own. This block therefore produces that die's per-channel shift, capture and update strobes. It does the same for the DRAM die's wrapper chain. The wrapper cells facing the DRAM die have their test/functional multiplexer inside the pad, so the block also drives the select for that multiplexer.

Each memory channel can be taken out of the path. An excluded channel is replaced by a single bypass flop, so the path length stays predictable, and its strobes stay low so its contents are preserved.

Top module: `mtower_scan_cfg`

## Requirements
- R1: The instruction register is 8 bits. Bits [3:0] hold the mode code and bits [7:4] hold the channel mask, with bit 4+c enabling channel c. It shifts from tdi_i toward tdo_o, LSB out first, while shift_ir_i is high. During that shift, tdo_o shows the bits currently in the shift stage, which are the word loaded last. Code and mask are updated only on update_ir_i. After reset, the code is 0 and the mask is 4'hF.
- R2: Every segment loads its parallel value on capture_dr_i and shifts toward tdo_o on shift_dr_i, with bit 0 leaving first. Code 0 and codes 6 to 15 select a single bypass flop that captures 0.
- R3: Code 1 (die internal test) gives the path tdi_i → north wrapper cells → east wrapper cells → tdo_o.
- R4: Code 2 (integrated interconnect) gives the path tdi_i → north wrapper → memory channels 0 to 3 → east wrapper → DRAM die chain → tdo_o.
- R5: Code 3 (north tower only) gives the path tdi_i → north wrapper → memory channels 0 to 3 → tdo_o.
- R6: Code 4 (east tower only) gives the path tdi_i → east wrapper → DRAM die chain → tdo_o.
- R7: Code 5 (board-level boundary scan) gives the path tdi_i → package-pin boundary cells → tdo_o.
- R8: When a channel's mask bit is 0, that channel is replaced in the path by one bypass flop that captures 0. The channel's strobes then stay low, so its contents are left unchanged.
- R9: mem_shift_o[c], mem_capture_o[c] and mem_update_o[c] follow shift_dr_i, capture_dr_i and update_dr_i when the mode is 2 or 3 and mask bit c is 1. Otherwise they are 0.
- R10: dram_shift_o, dram_capture_o and dram_update_o follow the three DR strobes in modes 2 and 4. Otherwise they are 0.
- R11: east_test_sel_o is 1 exactly in modes 1, 2 and 4.
- R12: While a new instruction is being shifted, the previous mode and its path and strobes stay in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tdi_i | input | 1 | Serial test data in |
| shift_ir_i | input | 1 | Instruction shift state |
| update_ir_i | input | 1 | Instruction update state |
| capture_dr_i | input | 1 | Data capture state |
| shift_dr_i | input | 1 | Data shift state |
| update_dr_i | input | 1 | Data update state |
| tdo_o | output | 1 | Serial test data out |
| bnd_cap_i | input | BND_LEN | Capture values of package-pin boundary cells |
| wn_cap_i | input | WN_LEN | Capture values of north-facing wrapper cells |
| we_cap_i | input | WE_LEN | Capture values of east-facing wrapper cells |
| dram_si_o | output | 1 | Serial data into the DRAM die chain |
| dram_so_i | input | 1 | Serial data from the DRAM die chain |
| dram_shift_o | output | 1 | DRAM chain shift strobe |
| dram_capture_o | output | 1 | DRAM chain capture strobe |
| dram_update_o | output | 1 | DRAM chain update strobe |
| mem_si_o | output | NCH | Serial data into each memory channel |
| mem_so_i | input | NCH | Serial data from each memory channel |
| mem_shift_o | output | NCH | Per-channel shift strobe |
| mem_capture_o | output | NCH | Per-channel capture strobe |
| mem_update_o | output | NCH | Per-channel update strobe |
| east_test_sel_o | output | 1 | Test select for pad-embedded east multiplexers |

## Verification
The overlap that matters most is a new instruction shifting in while the old mode is still active. Midway through every instruction load, the bench compares the east pad select with the value the previous mode implies, and it compares the bits leaving tdo_o with the previously loaded word. Path length and segment order are then checked together by one scan per mode and mask. The first bits out must equal the captured values in path order, and the following bits must be the scan-in pattern delayed by exactly the expected length. For each excluded channel, the bench also confirms that its model register is unchanged.

// File: rtl/mtsc_pkg.sv
`timescale 1ns/1ps
package mtsc_pkg;
  localparam int CODE_W = 4;

  typedef enum logic [CODE_W-1:0] {
    M_BYPASS = 4'd0,
    M_INTEST = 4'd1,
    M_INTEG  = 4'd2,
    M_NORTH  = 4'd3,
    M_EAST   = 4'd4,
    M_BSCAN  = 4'd5
  } mode_e;

  typedef struct packed {
    logic wn;
    logic mem;
    logic we;
    logic dram;
    logic bnd;
    logic byp;
  } seg_act_t;

  function automatic seg_act_t decode_mode(logic [CODE_W-1:0] code);
    seg_act_t a;
    a = '0;
    case (code)
      M_INTEST: begin a.wn = 1'b1; a.we = 1'b1; end
      M_INTEG:  begin a.wn = 1'b1; a.mem = 1'b1; a.we = 1'b1; a.dram = 1'b1; end
      M_NORTH:  begin a.wn = 1'b1; a.mem = 1'b1; end
      M_EAST:   begin a.we = 1'b1; a.dram = 1'b1; end
      M_BSCAN:  a.bnd = 1'b1;
      default:  a.byp = 1'b1;
    endcase
    return a;
  endfunction
endpackage

// File: rtl/mtsc_seg.sv
`timescale 1ns/1ps
module mtsc_seg #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cap_en_i,
  input  logic         shift_en_i,
  input  logic [N-1:0] cap_d_i,
  input  logic         si_i,
  output logic         so_o
);
  logic [N-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         sr_q <= '0;
    else if (cap_en_i)   sr_q <= cap_d_i;
    else if (shift_en_i) begin
      if (N == 1) sr_q <= N'(si_i);
      else        sr_q <= {si_i, sr_q[N-1:1]};
    end
  end

  assign so_o = sr_q[0];
endmodule

// File: rtl/mtsc_wir.sv
`timescale 1ns/1ps
module mtsc_wir
  import mtsc_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tdi_i,
  input  logic              shift_i,
  input  logic              update_i,
  output logic              so_o,
  output logic [CODE_W-1:0] code_o,
  output logic [NCH-1:0]    mask_o
);
  localparam int W = CODE_W + NCH;
  localparam logic [W-1:0] RST_WORD = {{NCH{1'b1}}, CODE_W'(M_BYPASS)};

  logic [W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= RST_WORD;
    else if (shift_i) sr_q <= {tdi_i, sr_q[W-1:1]};
  end

  // active word changes only on update; shifting never disturbs it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_o <= CODE_W'(M_BYPASS);
      mask_o <= '1;
    end else if (update_i) begin
      code_o <= sr_q[CODE_W-1:0];
      mask_o <= sr_q[W-1:CODE_W];
    end
  end

  assign so_o = sr_q[0];
endmodule

// File: rtl/mtsc_mem_path.sv
`timescale 1ns/1ps
module mtsc_mem_path #(
  parameter int NCH = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           act_i,
  input  logic [NCH-1:0] mask_i,
  input  logic           shift_i,
  input  logic           capture_i,
  input  logic           update_i,
  input  logic           si_i,
  output logic           so_o,
  output logic [NCH-1:0] mem_si_o,
  input  logic [NCH-1:0] mem_so_i,
  output logic [NCH-1:0] mem_shift_o,
  output logic [NCH-1:0] mem_capture_o,
  output logic [NCH-1:0] mem_update_o
);
  logic [NCH:0] link;
  assign link[0] = si_i;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic inc, byp_act, byp_so;
    assign inc     = act_i & mask_i[c];
    assign byp_act = act_i & ~mask_i[c];

    mtsc_seg #(.N(1)) u_byp (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cap_en_i   (byp_act & capture_i),
      .shift_en_i (byp_act & shift_i),
      .cap_d_i    (1'b0),
      .si_i       (link[c]),
      .so_o       (byp_so)
    );

    assign mem_si_o[c]      = inc ? link[c] : 1'b0;
    assign mem_shift_o[c]   = inc & shift_i;
    assign mem_capture_o[c] = inc & capture_i;
    assign mem_update_o[c]  = inc & update_i;
    assign link[c+1]        = mask_i[c] ? mem_so_i[c] : byp_so;
  end

  assign so_o = link[NCH];
endmodule

// File: rtl/mtower_scan_cfg.sv
`timescale 1ns/1ps
module mtower_scan_cfg
  import mtsc_pkg::*;
#(
  parameter int NCH     = 4,
  parameter int BND_LEN = 8,
  parameter int WN_LEN  = 6,
  parameter int WE_LEN  = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tdi_i,
  input  logic               shift_ir_i,
  input  logic               update_ir_i,
  input  logic               capture_dr_i,
  input  logic               shift_dr_i,
  input  logic               update_dr_i,
  output logic               tdo_o,
  input  logic [BND_LEN-1:0] bnd_cap_i,
  input  logic [WN_LEN-1:0]  wn_cap_i,
  input  logic [WE_LEN-1:0]  we_cap_i,
  output logic               dram_si_o,
  input  logic               dram_so_i,
  output logic               dram_shift_o,
  output logic               dram_capture_o,
  output logic               dram_update_o,
  output logic [NCH-1:0]     mem_si_o,
  input  logic [NCH-1:0]     mem_so_i,
  output logic [NCH-1:0]     mem_shift_o,
  output logic [NCH-1:0]     mem_capture_o,
  output logic [NCH-1:0]     mem_update_o,
  output logic               east_test_sel_o
);
  logic [CODE_W-1:0] code;
  logic [NCH-1:0]    mask;
  logic              ir_so, wn_so, we_so, mem_so, bnd_so, byp_so, we_si;
  seg_act_t          act;

  mtsc_wir #(.NCH(NCH)) u_wir (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tdi_i    (tdi_i),
    .shift_i  (shift_ir_i),
    .update_i (update_ir_i),
    .so_o     (ir_so),
    .code_o   (code),
    .mask_o   (mask)
  );

  assign act = decode_mode(code);

  mtsc_seg #(.N(WN_LEN)) u_wn (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .cap_en_i (act.wn & capture_dr_i), .shift_en_i (act.wn & shift_dr_i),
    .cap_d_i (wn_cap_i), .si_i (tdi_i), .so_o (wn_so)
  );

  mtsc_mem_path #(.NCH(NCH)) u_mem (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .act_i (act.mem), .mask_i (mask),
    .shift_i (shift_dr_i), .capture_i (capture_dr_i), .update_i (update_dr_i),
    .si_i (wn_so), .so_o (mem_so),
    .mem_si_o (mem_si_o), .mem_so_i (mem_so_i),
    .mem_shift_o (mem_shift_o), .mem_capture_o (mem_capture_o),
    .mem_update_o (mem_update_o)
  );

  // east wrapper input: after memory, after north wrapper, or straight from TDI
  assign we_si = act.mem ? mem_so : (act.wn ? wn_so : tdi_i);

  mtsc_seg #(.N(WE_LEN)) u_we (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .cap_en_i (act.we & capture_dr_i), .shift_en_i (act.we & shift_dr_i),
    .cap_d_i (we_cap_i), .si_i (we_si), .so_o (we_so)
  );

  mtsc_seg #(.N(BND_LEN)) u_bnd (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .cap_en_i (act.bnd & capture_dr_i), .shift_en_i (act.bnd & shift_dr_i),
    .cap_d_i (bnd_cap_i), .si_i (tdi_i), .so_o (bnd_so)
  );

  mtsc_seg #(.N(1)) u_byp (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .cap_en_i (act.byp & capture_dr_i), .shift_en_i (act.byp & shift_dr_i),
    .cap_d_i (1'b0), .si_i (tdi_i), .so_o (byp_so)
  );

  assign dram_si_o      = act.dram ? we_so : 1'b0;
  assign dram_shift_o   = act.dram & shift_dr_i;
  assign dram_capture_o = act.dram & capture_dr_i;
  assign dram_update_o  = act.dram & update_dr_i;
  assign east_test_sel_o = act.we;

  always_comb begin
    if (shift_ir_i)    tdo_o = ir_so;
    else if (act.dram) tdo_o = dram_so_i;
    else if (act.we)   tdo_o = we_so;
    else if (act.mem)  tdo_o = mem_so;
    else if (act.bnd)  tdo_o = bnd_so;
    else               tdo_o = byp_so;
  end
endmodule

// File: rtl/mtsc_sva.sv
`timescale 1ns/1ps
module mtsc_sva #(
  parameter int NCH = 4
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           update_ir_i,
  input logic           shift_dr_i,
  input logic           capture_dr_i,
  input logic [NCH-1:0] mem_shift_o,
  input logic [NCH-1:0] mem_capture_o,
  input logic           dram_shift_o,
  input logic           dram_capture_o,
  input logic           east_test_sel_o
);
  a_r9_mem_shift_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|mem_shift_o) |-> shift_dr_i);

  a_r9_mem_cap_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|mem_capture_o) |-> capture_dr_i);

  a_r10_dram_cap_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dram_capture_o |-> capture_dr_i);

  a_r11_dram_needs_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dram_shift_o |-> east_test_sel_o);

  a_r12_mode_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !update_ir_i |=> $stable(east_test_sel_o));
endmodule

bind mtower_scan_cfg mtsc_sva #(.NCH(NCH)) u_sva (.*);

// File: tb/mtower_scan_cfg_test.sv
`timescale 1ns/1ps
module mtower_scan_cfg_test;
  localparam int NCH = 4, BND = 8, WN = 6, WE = 5, ML = 4, DL = 7;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, tdi = 1'b0;
  logic shift_ir = 0, update_ir = 0, capture_dr = 0, shift_dr = 0, update_dr = 0;
  logic tdo;
  logic [BND-1:0] bnd_cap = '0;
  logic [WN-1:0]  wn_cap = '0;
  logic [WE-1:0]  we_cap = '0;
  logic dram_si, dram_so, dram_sh, dram_cp, dram_up, east_sel;
  logic [NCH-1:0] mem_si, mem_so, mem_sh, mem_cp, mem_up;

  mtower_scan_cfg #(.NCH(NCH), .BND_LEN(BND), .WN_LEN(WN), .WE_LEN(WE)) uut (
    .clk_i (clk), .rst_ni (rst_n), .tdi_i (tdi),
    .shift_ir_i (shift_ir), .update_ir_i (update_ir),
    .capture_dr_i (capture_dr), .shift_dr_i (shift_dr), .update_dr_i (update_dr),
    .tdo_o (tdo), .bnd_cap_i (bnd_cap), .wn_cap_i (wn_cap), .we_cap_i (we_cap),
    .dram_si_o (dram_si), .dram_so_i (dram_so), .dram_shift_o (dram_sh),
    .dram_capture_o (dram_cp), .dram_update_o (dram_up),
    .mem_si_o (mem_si), .mem_so_i (mem_so), .mem_shift_o (mem_sh),
    .mem_capture_o (mem_cp), .mem_update_o (mem_up), .east_test_sel_o (east_sel)
  );

  // neighbour die models
  logic [DL-1:0] dreg = '0;
  localparam logic [DL-1:0] DCAP = 7'h5A;
  logic [ML-1:0] mreg [NCH];
  logic [ML-1:0] mcap [NCH];
  initial for (int c = 0; c < NCH; c++) begin mreg[c] = '0; mcap[c] = ML'(c * 3 + 5); end

  always @(posedge clk) begin
    if (dram_cp) dreg <= DCAP;
    else if (dram_sh) dreg <= {dram_si, dreg[DL-1:1]};
  end
  assign dram_so = dreg[0];

  for (genvar c = 0; c < NCH; c++) begin : g_m
    always @(posedge clk) begin
      if (mem_cp[c]) mreg[c] <= mcap[c];
      else if (mem_sh[c]) mreg[c] <= {mem_si[c], mreg[c][ML-1:1]};
    end
    assign mem_so[c] = mreg[c][0];
  end

  int n_chk = 0, n_bad = 0;
  logic [7:0] ir_prev = 8'hF0;
  logic [3:0] cur_code = 4'd0;

  task automatic chk(string rq, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic string mode_req(logic [3:0] code);
    case (code)
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      5: return "R7";
      default: return "R2";
    endcase
  endfunction

  function automatic logic sel_exp(logic [3:0] code);
    return code == 1 || code == 2 || code == 4;
  endfunction

  function automatic void add(inout logic [63:0] s, inout int len, input logic [63:0] v, input int w);
    for (int i = 0; i < w; i++) s[len+i] = v[i];
    len += w;
  endfunction

  // expected capture stream, first bit to leave tdo at index 0
  function automatic void build(input logic [3:0] code, input logic [3:0] mask,
                                output logic [63:0] s, output int len);
    s = '0; len = 0;
    case (code)
      1: begin add(s, len, 64'(we_cap), WE); add(s, len, 64'(wn_cap), WN); end
      2, 3: begin
        if (code == 2) begin add(s, len, 64'(DCAP), DL); add(s, len, 64'(we_cap), WE); end
        for (int c = NCH - 1; c >= 0; c--)
          if (mask[c]) add(s, len, 64'(mcap[c]), ML); else add(s, len, 64'd0, 1);
        add(s, len, 64'(wn_cap), WN);
      end
      4: begin add(s, len, 64'(DCAP), DL); add(s, len, 64'(we_cap), WE); end
      5: add(s, len, 64'(bnd_cap), BND);
      default: add(s, len, 64'd0, 1);
    endcase
  endfunction

  task automatic load_ir(logic [3:0] code, logic [3:0] mask);
    logic [7:0] w, got;
    w = {mask, code};
    got = '0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); shift_ir = 1'b1; tdi = w[i];
      #1 got[i] = tdo;
      if (i == 4) chk("R12 old mode held during IR shift", 64'(east_sel), 64'(sel_exp(cur_code)));
    end
    @(negedge clk); shift_ir = 1'b0; update_ir = 1'b1;
    @(negedge clk); update_ir = 1'b0;
    chk("R1 IR shift-out shows previous word", 64'(got), 64'(ir_prev));
    ir_prev = w;
    cur_code = code;
    #1 chk("R11 east test select", 64'(east_sel), 64'(sel_exp(code)));
  endtask

  task automatic scan(logic [3:0] code, logic [3:0] mask);
    logic [63:0] cs, got, pat, lmask;
    logic [7:0] tail;
    logic [ML-1:0] snap [NCH];
    int len;
    logic mem_mode, dram_mode;
    mem_mode  = code == 2 || code == 3;
    dram_mode = code == 2 || code == 4;
    bnd_cap = BND'($urandom); wn_cap = WN'($urandom); we_cap = WE'($urandom);
    build(code, mask, cs, len);
    for (int c = 0; c < NCH; c++) snap[c] = mreg[c];
    pat = {$urandom, $urandom};
    got = '0; tail = '0;
    @(negedge clk); capture_dr = 1'b1;
    for (int i = 0; i < len + 8; i++) begin
      @(negedge clk); capture_dr = 1'b0; shift_dr = 1'b1; tdi = pat[i];
      #1;
      if (i < len) got[i] = tdo; else tail[i-len] = tdo;
    end
    @(negedge clk); shift_dr = 1'b0; update_dr = 1'b1;
    #1;
    chk("R9 memory update strobes", 64'(mem_up), mem_mode ? 64'(mask) : 64'd0);
    chk("R10 DRAM update strobe", 64'(dram_up), 64'(dram_mode));
    @(negedge clk); update_dr = 1'b0;
    lmask = (64'd1 << len) - 64'd1;
    chk({mode_req(code), " captured stream order"}, got & lmask, cs);
    chk({mode_req(code), " path length"}, 64'(tail), 64'(pat[7:0]));
    if (mem_mode)
      for (int c = 0; c < NCH; c++)
        if (!mask[c]) chk("R8 excluded channel untouched", 64'(mreg[c]), 64'(snap[c]));
  endtask

  initial begin
    repeat (1000 * 150) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h1F0E5A11));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R11 reset select low", 64'(east_sel), 64'd0);
    chk("R9 reset memory strobes low", 64'({mem_sh, mem_cp, mem_up}), 64'd0);
    scan(4'd0, 4'hF);                         // R2 reset bypass
    for (int m = 0; m < 6; m++) begin
      load_ir(4'(m), 4'hF);
      scan(4'(m), 4'hF);
    end
    for (int k = 0; k < 16; k++) begin        // R4 R8 every mask
      load_ir(4'd2, 4'(k));
      scan(4'd2, 4'(k));
    end
    load_ir(4'd3, 4'h0); scan(4'd3, 4'h0);    // R5 R8 all channels out
    load_ir(4'd9, 4'h5); scan(4'd9, 4'h5);    // R2 unused code
    load_ir(4'd15, 4'hA); scan(4'd15, 4'hA);
    for (int r = 0; r < 30; r++) begin
      logic [3:0] c, mk;
      c = 4'($urandom % 8); mk = 4'($urandom);
      load_ir(c, mk);
      scan(c, mk);
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule